// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block sits on the host side of a parallel NOR-style flash and decides whether an embedded program or erase operation has finished or failed. It is started once the command sequence has been written, that is after the final write strobe. A single start pulse carries the expected byte, the operation kind and the address to watch. The block then reads that address over and over through a simple request/acknowledge read port until a verdict is reached.

While the operation is busy the device drives a status pattern on bit 7, and it sets bit 5 once its internal time limit has passed. Bit 7 can change on the same read that bit 5 first shows set. For that reason a set bit 5 does not fail the operation at once: the block reads one more time and fails only if bit 7 is still wrong on that read. The lower bits may not be valid yet on the read where bit 7 first matches. So after a match the block makes one further read and returns that full byte as its result. A parameterised limit on the number of plain busy polls ends a hung wait with a separate timeout flag.

Top module: `nor_poll_ctrl`

## Requirements
- R1: A start pulse is taken only while the block is idle (busy_o low). A start pulse that arrives while busy_o is high changes neither the polled address nor the verdict. busy_o rises in the cycle after an accepted start and stays high up to and including the done cycle.
- R2: rd_req_o is high in every cycle in which the block waits for a read, and rd_addr_o then equals the address captured at start. A read completes in each cycle where rd_req_o and rd_ack_i are both high at a rising clock edge, and rd_data_i is taken in that cycle.
- R3: The wanted value of bit 7 (mask 0x80) is 1 for an erase (op_erase_i = 1). For a program (op_erase_i = 0) it is bit 7 of exp_data_i. A poll read whose bit 7 equals the wanted value takes the pass path.
- R4: A poll read whose bit 7 differs from the wanted value and whose bit 5 (mask 0x20) is 0 leads to another poll read of the same address.
- R5: A poll read whose bit 7 differs and whose bit 5 is 1 leads to exactly one recheck read. If bit 7 matches on the recheck, the pass path follows. Otherwise the verdict is fail with timeout_o low, and result_o is set to the recheck byte.
- R6: On the pass path the block makes exactly one further read, returns that byte on result_o and sets pass_o.
- R7: When MAX_POLLS poll reads in a row end with bit 7 wrong and bit 5 clear, the verdict is fail with timeout_o high, and result_o is set to the last byte read. A set bit 5 on the last allowed poll still leads to the recheck of R5.
- R8: done_o is a one-cycle pulse that comes one cycle after the deciding read. Exactly one of pass_o and fail_o is high at done. The flags and result_o keep their values until the next accepted start.
- R9: After reset the block is idle: busy_o, done_o, rd_req_o, pass_o, fail_o and timeout_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| exp_data_i | input | DW | Expected byte (program data) |
| addr_i | input | AW | Address to poll |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Operation under watch |
| done_o | output | 1 | One-cycle verdict pulse |
| pass_o | output | 1 | Verdict: operation completed |
| fail_o | output | 1 | Verdict: operation failed |
| timeout_o | output | 1 | Fail caused by the poll limit |
| result_o | output | DW | Byte from the final read |

## Verification
The assertions check on every cycle the rules that hold at any time. done_o lasts one cycle and carries exactly one verdict, and a timeout always comes with a fail. The request address stays fixed while a read is pending, a start during busy leaves the captured target alone, a failed recheck leads straight to a fail, and the poll counter never goes past its limit. Only the bench's scenarios can show the chosen decision paths. These are the bit-5 recheck that passes or fails, the extra read for the result byte, the timeout on the last allowed poll against a bit 5 that shows up on that same poll, and the exact number of reads each verdict takes. The bench checks these against scripted device replies with random acknowledge latency.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_POLL    = 3'd1,
    ST_RECHECK = 3'd2,
    ST_CONFIRM = 3'd3,
    ST_DONE    = 3'd4
  } poll_state_e;

  typedef enum logic [2:0] {
    DEC_NONE    = 3'd0,
    DEC_HIT     = 3'd1,
    DEC_RETRY   = 3'd2,
    DEC_RECHECK = 3'd3,
    DEC_FAIL    = 3'd4,
    DEC_EXHAUST = 3'd5,
    DEC_FINAL   = 3'd6
  } poll_dec_e;

  // wanted status bit: erase completes with a 1, program with the true data bit
  function automatic logic target_bit(input logic is_erase, input logic exp_bit);
    return is_erase ? 1'b1 : exp_bit;
  endfunction

  function automatic logic status_ok(input logic got, input logic want);
    return got == want;
  endfunction

  function automatic logic is_read_state(input poll_state_e s);
    return (s == ST_POLL) || (s == ST_RECHECK) || (s == ST_CONFIRM);
  endfunction

endpackage

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic bump_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (bump_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_VAL);

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_POLLS));

endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import nor_poll_pkg::*;
#(
  parameter int DW        = 8,
  parameter int POLL_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  poll_state_e state_i,
  input  logic        ack_i,
  input  logic [DW-1:0] data_i,
  input  logic        target_i,
  input  logic        budget_last_i,
  output poll_dec_e   dec_o
);
  logic hit, limit_seen;
  assign hit        = status_ok(data_i[POLL_BIT], target_i);
  assign limit_seen = data_i[LIMIT_BIT];

  always_comb begin
    dec_o = DEC_NONE;
    if (ack_i) begin
      unique case (state_i)
        ST_POLL: begin
          if (hit)                dec_o = DEC_HIT;
          else if (limit_seen)    dec_o = DEC_RECHECK;
          else if (budget_last_i) dec_o = DEC_EXHAUST;
          else                    dec_o = DEC_RETRY;
        end
        ST_RECHECK: dec_o = hit ? DEC_HIT : DEC_FAIL;
        ST_CONFIRM: dec_o = DEC_FINAL;
        default:    dec_o = DEC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import nor_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  poll_dec_e   dec_i,
  output poll_state_e state_o
);
  poll_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = ST_POLL;
      ST_POLL: begin
        unique case (dec_i)
          DEC_HIT:     state_d = ST_CONFIRM;
          DEC_RECHECK: state_d = ST_RECHECK;
          DEC_EXHAUST: state_d = ST_DONE;
          default:     state_d = ST_POLL;
        endcase
      end
      ST_RECHECK: begin
        if (dec_i == DEC_HIT)       state_d = ST_CONFIRM;
        else if (dec_i == DEC_FAIL) state_d = ST_DONE;
      end
      ST_CONFIRM: if (dec_i == DEC_FINAL) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  a_r6_confirm_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONFIRM && dec_i == DEC_FINAL) |=> state_q == ST_DONE);

  a_r8_done_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> state_q == ST_IDLE);

endmodule

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
  import nor_poll_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter int MAX_POLLS = 16,
  parameter int POLL_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic [DW-1:0] result_o
);
  poll_state_e   state;
  poll_dec_e     dec;
  logic          accept;
  logic          target_q;
  logic [AW-1:0] addr_q;
  logic          budget_last;
  logic [DW-1:0] result_q;
  logic          pass_q, fail_q, tmo_q;

  // named events for the checks
  logic ev_hit, ev_retry, ev_suspect, ev_recheck_miss, ev_exhaust, ev_final;

  assign accept          = start_i && (state == ST_IDLE);
  assign ev_hit          = (dec == DEC_HIT);
  assign ev_retry        = (dec == DEC_RETRY);
  assign ev_suspect      = (dec == DEC_RECHECK);
  assign ev_recheck_miss = (dec == DEC_FAIL);
  assign ev_exhaust      = (dec == DEC_EXHAUST);
  assign ev_final        = (dec == DEC_FINAL);

  poll_judge #(.DW(DW), .POLL_BIT(POLL_BIT), .LIMIT_BIT(LIMIT_BIT)) u_judge (
    .state_i      (state),
    .ack_i        (rd_ack_i),
    .data_i       (rd_data_i),
    .target_i     (target_q),
    .budget_last_i(budget_last),
    .dec_o        (dec)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(accept),
    .bump_i (ev_retry),
    .last_o (budget_last)
  );

  poll_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept),
    .dec_i   (dec),
    .state_o (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= 1'b0;
      addr_q   <= '0;
    end else if (accept) begin
      target_q <= target_bit(op_erase_i, exp_data_i[POLL_BIT]);
      addr_q   <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else if (accept) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (ev_final) begin
      result_q <= rd_data_i;
      pass_q   <= 1'b1;
    end else if (ev_recheck_miss) begin
      result_q <= rd_data_i;
      fail_q   <= 1'b1;
    end else if (ev_exhaust) begin
      result_q <= rd_data_i;
      fail_q   <= 1'b1;
      tmo_q    <= 1'b1;
    end
  end

  assign rd_req_o  = is_read_state(state);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;
  assign result_o  = result_q;

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));

  a_r7_timeout_is_fail: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> fail_o);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r1_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(target_q) && $stable(addr_q)));

  a_r5_recheck_miss_fails: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recheck_miss |=> (done_o && fail_o && !timeout_o));

  a_r4_retry_keeps_polling: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (rd_req_o && busy_o && !done_o));

endmodule

// File: tb/sim_nor_poll_ctrl.sv
module sim_nor_poll_ctrl;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, op_erase_i = 1'b0, rd_ack_i = 1'b0;
  logic [DW-1:0] exp_data_i = '0, rd_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic rd_req_o, busy_o, done_o, pass_o, fail_o, timeout_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] result_o;

  always #5 clk = ~clk;

  nor_poll_ctrl #(.DW(DW), .AW(AW), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .exp_data_i(exp_data_i), .addr_i(addr_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .result_o(result_o));

  int n_run = 0, n_fail = 0;
  logic [7:0] script [0:63];
  int rd_idx = 0;
  int addr_err = 0;
  logic [AW-1:0] want_addr = '0;
  bit lat_rand = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device reply model: serves the script in order, random ack latency
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (lat == 0) begin
          rd_ack_i  = 1'b1;
          rd_data_i = script[rd_idx & 63];
          if (rd_addr_o != want_addr) addr_err++;
          rd_idx++;
          lat = lat_rand ? int'($urandom_range(0, 2)) : 0;
        end else begin
          rd_ack_i = 1'b0;
          lat--;
        end
      end else begin
        rd_ack_i = 1'b0;
      end
    end
  end

  // independent outcome model built from R3..R7
  task automatic predict(input bit erase, input logic [7:0] exp,
                         output bit ps, output bit fl, output bit to,
                         output logic [7:0] res, output int reads);
    logic want;
    int i, polls;
    logic [7:0] d;
    want = erase ? 1'b1 : exp[7];
    i = 0; polls = 0;
    ps = 0; fl = 0; to = 0; res = '0;
    forever begin
      d = script[i]; i++;
      if (d[7] == want) begin
        res = script[i]; i++; ps = 1; break;
      end else if (d[5]) begin
        d = script[i]; i++;
        if (d[7] == want) begin res = script[i]; i++; ps = 1; end
        else begin res = d; fl = 1; end
        break;
      end else begin
        polls++;
        if (polls == MAXP) begin res = d; fl = 1; to = 1; break; end
      end
    end
    reads = i;
  endtask

  task automatic run_op(input bit erase, input logic [7:0] exp,
                        input logic [AW-1:0] addr, input bit poke,
                        input string tag);
    bit ps, fl, to;
    logic [7:0] res;
    int reads, cyc;
    bit seen;
    predict(erase, exp, ps, fl, to, res, reads);
    rd_idx = 0; addr_err = 0; want_addr = addr;
    @(negedge clk);
    start_i = 1'b1; op_erase_i = erase; exp_data_i = exp; addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1", {tag, " busy after start"}, busy_o, 1);
    cyc = 0; seen = 0;
    while (cyc < 400) begin
      if (done_o) begin seen = 1; break; end
      if (poke && cyc == 1) begin
        start_i = 1'b1; op_erase_i = ~erase; exp_data_i = ~exp; addr_i = ~addr;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (!done_o) check(busy_o == 1'b1, "R1", {tag, " busy held"}, busy_o, 1);
    end
    start_i = 1'b0;
    check(seen, "R8", {tag, " done seen (watchdog)"}, seen, 1);
    if (!seen) return;
    check(pass_o == ps && fail_o == fl, "R8", {tag, " verdict"},
          {pass_o, fail_o}, {ps, fl});
    check(timeout_o == to, "R7", {tag, " timeout flag"}, timeout_o, to);
    check(result_o == res, "R6", {tag, " result byte"}, result_o, res);
    check(rd_idx == reads, "R4", {tag, " read count"}, rd_idx, reads);
    check(addr_err == 0, "R2", {tag, " read address"}, addr_err, 0);
    @(negedge clk);
    check(!done_o && !busy_o, "R8", {tag, " done one cycle"}, {done_o, busy_o}, 0);
    check(pass_o == ps && fail_o == fl && result_o == res, "R8",
          {tag, " flags held"}, {pass_o, fail_o}, {ps, fl});
  endtask

  task automatic fill(input logic [7:0] v []);
    for (int k = 0; k < 64; k++) script[k] = (k < v.size()) ? v[k] : 8'h00;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy_o && !done_o && !rd_req_o, "R9", "reset idle", {busy_o, done_o, rd_req_o}, 0);
    check(!pass_o && !fail_o && !timeout_o, "R9", "reset flags", {pass_o, fail_o, timeout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill('{8'h05, 8'h05, 8'h80, 8'hA5});
    run_op(1'b0, 8'hA5, 16'h1234, 1'b0, "R3 program bit7=1");
    fill('{8'h00, 8'h00, 8'h40, 8'hFF, 8'hFF});
    run_op(1'b1, 8'h00, 16'h0100, 1'b0, "R3 erase");
    fill('{8'h80, 8'h00, 8'h12});
    run_op(1'b0, 8'h12, 16'hBEEF, 1'b0, "R3 program bit7=0");
    fill('{8'h20, 8'h80, 8'h83});
    run_op(1'b0, 8'h80, 16'h0042, 1'b0, "R5 recheck pass");
    fill('{8'h20, 8'h24, 8'hFF});
    run_op(1'b1, 8'h00, 16'h0043, 1'b0, "R5 recheck fail");
    fill('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF});
    run_op(1'b1, 8'h00, 16'h7000, 1'b0, "R7 timeout");
    fill('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'hFF, 8'h11});
    run_op(1'b1, 8'h00, 16'h7001, 1'b0, "R7 bit5 on last poll");
    fill('{8'h01, 8'h02, 8'h03, 8'h80, 8'h9C});
    run_op(1'b0, 8'hC3, 16'h5555, 1'b1, "R1 start while busy");

    lat_rand = 1'b1;
    for (int t = 0; t < 150; t++) begin
      bit er;
      logic [7:0] ex;
      logic want;
      er = 1'($urandom_range(0, 1));
      ex = 8'($urandom);
      want = er ? 1'b1 : ex[7];
      for (int k = 0; k < 64; k++) begin
        logic [7:0] b;
        b = 8'($urandom);
        b[7] = ($urandom_range(0, 9) < 2) ? want : ~want;
        b[5] = ($urandom_range(0, 9) < 1);
        script[k] = b;
      end
      run_op(er, ex, 16'($urandom), 1'($urandom_range(0, 3) == 0), "R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(1_500_000);
    n_run++; n_fail++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule